// File: doc/BRIEF.md
# Stereo Audio Codec Serial Port

This block connects a parallel, word-at-a-time user interface to an external stereo audio converter chip. The converter has one ADC and one DAC per channel. All three converter clocks come from a single free-running counter in the system clock domain: an oversampling clock, a channel-framing clock and a bit clock. Serial capture and serial transmit both run on clock-enable pulses taken from that counter, so the block uses no derived clock.

On the user side each channel has its own ADC result register and its own DAC source register, and each has a ready flag. A one-bit channel select (0 = left, 1 = right) picks the channel that a single-cycle read strobe or write strobe acts on. A read takes the selected ADC word and clears that ADC flag. A write loads the selected DAC bus and clears that DAC flag. The receive side runs a slot state machine with the states LEAD (the lead-in bit period after a channel edge), DATA (eight sampled bits) and PAD (the rest of the slot). Its transitions are LEAD→DATA at the sample pulse of bit period 0, DATA→PAD at the sample pulse of the last data bit, and PAD→LEAD at the sample pulse of the last period of the slot. The transmit side runs the states IDLE (driving zeros) and SEND (shifting data out). Its transitions are IDLE→SEND at the drive pulse that ends bit period 0, and SEND→IDLE at the drive pulse that ends the last data bit period.

Top module: `codec_serial_port`

## Requirements
- R1: While reset is high and on the first cycle after it, the three converter clocks, the serial output and all four ready flags are 0.
- R2: The oversampling clock has a period of 2 system cycles. The bit clock has a period of 8 system cycles, which is 4 oversampling periods, and it changes only on a falling edge of the oversampling clock.
- R3: The framing clock is low for the left slot and high for the right slot. Each level lasts 32 bit-clock periods (256 system cycles), and it changes only together with a falling edge of the bit clock.
- R4: The serial input is sampled on rising bit-clock edges. Bit periods 1 to 8 after a framing-clock edge carry the sample MSB first. After the 8th bit, the word appears on the ADC bus of the channel whose slot it was, and that channel's ADC ready flag goes to 1.
- R5: A read strobe clears the ADC ready flag of the selected channel on the next cycle and leaves the other channel's flag as it was.
- R6: A write strobe copies the selected channel's DAC input bus into that channel's source register and clears that channel's DAC ready flag on the next cycle. The other channel's DAC flag is unaffected.
- R7: When a channel's slot begins, its source register is moved into the transmit shifter and its DAC ready flag goes to 1. A write to that channel in the same cycle takes precedence for the flag.
- R8: The serial output changes only on falling bit-clock edges. It carries the DAC word MSB first in bit periods 1 to 8 of the slot and is 0 in every other bit period.
- R9: If no write reaches a channel between two of its slots, the word last written to that channel is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mclk | output | 1 | Oversampling clock to the converter |
| lrck | output | 1 | Channel framing clock, 0 = left slot |
| sclk | output | 1 | Serial bit clock |
| adc_sdata | input | 1 | Serial ADC data from the converter |
| dac_sdata | output | 1 | Serial DAC data to the converter |
| ch_sel | input | 1 | Channel for strobes, 0 = left, 1 = right |
| rd_stb | input | 1 | Read strobe for the selected ADC word |
| wr_stb | input | 1 | Write strobe for the selected DAC word |
| adc_left | output | 8 | Last captured left ADC word |
| adc_right | output | 8 | Last captured right ADC word |
| adc_left_rdy | output | 1 | New left ADC word waiting |
| adc_right_rdy | output | 1 | New right ADC word waiting |
| dac_left | input | 8 | Left DAC word to load |
| dac_right | input | 8 | Right DAC word to load |
| dac_left_rdy | output | 1 | Left DAC source register may be reloaded |
| dac_right_rdy | output | 1 | Right DAC source register may be reloaded |

## Verification
The flag properties assume that the channel select is a defined 0 or 1 whenever a strobe is high, and that strobes are never X. They also assume the serial input is settled by each rising bit-clock edge. The stimulus keeps to these assumptions. It drives every user input half a system cycle away from the active edge and holds the select steady around each one-cycle strobe. Its converter model changes the serial input only just after a falling bit-clock edge, which leaves four system cycles before the capture edge.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

    typedef enum logic [1:0] {
        RX_LEAD = 2'd0,
        RX_DATA = 2'd1,
        RX_PAD  = 2'd2
    } rx_state_t;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_t;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/codec_clkgen.sv
module codec_clkgen #(
    parameter int MCLK_LOG2 = 1,
    parameter int SCLK_LOG2 = 3,
    parameter int SLOT_LOG2 = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic                 mclk_o,
    output logic                 sclk_o,
    output logic                 lrck_o,
    output logic                 smp_en_o,
    output logic                 drv_en_o,
    output logic [SLOT_LOG2-1:0] bit_idx_o,
    output logic                 chan_o
);
    localparam int CNT_W = SCLK_LOG2 + SLOT_LOG2 + 1;
    localparam logic [SCLK_LOG2-1:0] HALF = SCLK_LOG2'(1 << (SCLK_LOG2 - 1));

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign mclk_o    = cnt_q[MCLK_LOG2-1];
    assign sclk_o    = cnt_q[SCLK_LOG2-1];
    assign lrck_o    = cnt_q[CNT_W-1];
    assign chan_o    = cnt_q[CNT_W-1];
    assign bit_idx_o = cnt_q[SCLK_LOG2 +: SLOT_LOG2];
    assign smp_en_o  = (cnt_q[SCLK_LOG2-1:0] == HALF);
    assign drv_en_o  = &cnt_q[SCLK_LOG2-1:0];

    p_sclk_on_mclk_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk_o) |-> $fell(mclk_o));

    p_lrck_on_sclk_fall_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(lrck_o) |-> $fell(sclk_o));

endmodule

// File: rtl/codec_adc_rx.sv
module codec_adc_rx
    import codec_port_pkg::*;
#(
    parameter int SAMPLE_W  = 8,
    parameter int SLOT_LOG2 = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_en_i,
    input  logic [SLOT_LOG2-1:0] bit_idx_i,
    input  logic                 chan_i,
    input  logic                 sdata_i,
    input  logic                 rd_i,
    input  logic                 sel_i,
    output logic [SAMPLE_W-1:0]  word_l_o,
    output logic [SAMPLE_W-1:0]  word_r_o,
    output logic [NUM_CH-1:0]    rdy_o
);
    localparam logic [SLOT_LOG2-1:0] LAST  = SLOT_LOG2'(SAMPLE_W);
    localparam logic [SLOT_LOG2-1:0] FIRST = SLOT_LOG2'(1);
    localparam logic [SLOT_LOG2-1:0] TOP   = '1;

    rx_state_t st_q, st_d;
    logic [SAMPLE_W-1:0] sh_q;
    logic [SAMPLE_W-1:0] hold_q [NUM_CH];
    logic [NUM_CH-1:0]   rdy_q;
    logic                done;

    assign done = smp_en_i && (st_q == RX_DATA) && (bit_idx_i == LAST);

    always_ff @(posedge clk) begin
        if (rst) st_q <= RX_LEAD;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_LEAD: if (smp_en_i && bit_idx_i == '0) st_d = RX_DATA;
            RX_DATA: if (done)                        st_d = RX_PAD;
            RX_PAD:  if (smp_en_i && bit_idx_i == TOP) st_d = RX_LEAD;
            default: st_d = RX_LEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            hold_q[0] <= '0;
            hold_q[1] <= '0;
        end else if (smp_en_i && st_q == RX_DATA) begin
            sh_q <= {sh_q[SAMPLE_W-2:0], sdata_i};
            if (done) hold_q[chan_i] <= {sh_q[SAMPLE_W-2:0], sdata_i};
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
        localparam logic CH = 1'(c);
        always_ff @(posedge clk) begin
            if (rst)                      rdy_q[c] <= 1'b0;
            else if (done && chan_i == CH) rdy_q[c] <= 1'b1;
            else if (rd_i && sel_i == CH)  rdy_q[c] <= 1'b0;
        end
    end

    assign word_l_o = hold_q[0];
    assign word_r_o = hold_q[1];
    assign rdy_o    = rdy_q;

    p_rx_window_r4: assert property (@(posedge clk) disable iff (rst)
        (smp_en_i && st_q == RX_DATA) |-> (bit_idx_i >= FIRST && bit_idx_i <= LAST));

    p_capture_sets_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> rdy_q[$past(chan_i)]);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !(done && chan_i == sel_i)) |=> !rdy_q[$past(sel_i)]);

endmodule

// File: rtl/codec_dac_tx.sv
module codec_dac_tx
    import codec_port_pkg::*;
#(
    parameter int SAMPLE_W  = 8,
    parameter int SLOT_LOG2 = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 drv_en_i,
    input  logic                 sclk_i,
    input  logic [SLOT_LOG2-1:0] bit_idx_i,
    input  logic                 chan_i,
    input  logic                 wr_i,
    input  logic                 sel_i,
    input  logic [SAMPLE_W-1:0]  word_l_i,
    input  logic [SAMPLE_W-1:0]  word_r_i,
    output logic [NUM_CH-1:0]    rdy_o,
    output logic                 sdata_o
);
    localparam logic [SLOT_LOG2-1:0] LAST = SLOT_LOG2'(SAMPLE_W);
    localparam logic [SLOT_LOG2-1:0] TOP  = '1;

    tx_state_t st_q, st_d;
    logic [SAMPLE_W-1:0] sh_q;
    logic [SAMPLE_W-1:0] hold_q [NUM_CH];
    logic [SAMPLE_W-1:0] din [NUM_CH];
    logic [NUM_CH-1:0]   rdy_q;
    logic                sd_q;
    logic                nxt_ch;
    logic                slot_load;
    logic                shift_out;
    logic                end_data;

    assign din[0]    = word_l_i;
    assign din[1]    = word_r_i;
    assign nxt_ch    = ~chan_i;
    assign slot_load = drv_en_i && (st_q == TX_IDLE) && (bit_idx_i == TOP);
    assign end_data  = drv_en_i && (st_q == TX_SEND) && (bit_idx_i == LAST);
    assign shift_out = drv_en_i && (((st_q == TX_IDLE) && (bit_idx_i == '0)) ||
                                    ((st_q == TX_SEND) && (bit_idx_i != LAST)));

    always_ff @(posedge clk) begin
        if (rst) st_q <= TX_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: if (drv_en_i && bit_idx_i == '0) st_d = TX_SEND;
            TX_SEND: if (end_data)                    st_d = TX_IDLE;
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            sd_q <= 1'b0;
        end else if (slot_load) begin
            sh_q <= hold_q[nxt_ch];
        end else if (shift_out) begin
            sd_q <= sh_q[SAMPLE_W-1];
            sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
        end else if (end_data) begin
            sd_q <= 1'b0;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        localparam logic CH = 1'(c);
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[c] <= '0;
                rdy_q[c]  <= 1'b0;
            end else if (wr_i && sel_i == CH) begin
                hold_q[c] <= din[c];
                rdy_q[c]  <= 1'b0;
            end else if (slot_load && nxt_ch == CH) begin
                rdy_q[c]  <= 1'b1;
            end
        end
    end

    assign rdy_o   = rdy_q;
    assign sdata_o = sd_q;

    p_write_clears_r6: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> !rdy_q[$past(sel_i)]);

    p_slot_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (slot_load && !(wr_i && sel_i == nxt_ch)) |=> rdy_q[$past(nxt_ch)]);

    p_sdata_on_sclk_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_q) |-> $fell(sclk_i));

endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
    import codec_port_pkg::*;
#(
    parameter int SAMPLE_W  = 8,
    parameter int MCLK_LOG2 = 1,
    parameter int SCLK_LOG2 = 3,
    parameter int SLOT_LOG2 = 5
) (
    input  logic                clk,
    input  logic                rst,
    output logic                mclk,
    output logic                lrck,
    output logic                sclk,
    input  logic                adc_sdata,
    output logic                dac_sdata,
    input  logic                ch_sel,
    input  logic                rd_stb,
    input  logic                wr_stb,
    output logic [SAMPLE_W-1:0] adc_left,
    output logic [SAMPLE_W-1:0] adc_right,
    output logic                adc_left_rdy,
    output logic                adc_right_rdy,
    input  logic [SAMPLE_W-1:0] dac_left,
    input  logic [SAMPLE_W-1:0] dac_right,
    output logic                dac_left_rdy,
    output logic                dac_right_rdy
);
    logic                 smp_en;
    logic                 drv_en;
    logic [SLOT_LOG2-1:0] bit_idx;
    logic                 chan;
    logic [NUM_CH-1:0]    adc_rdy;
    logic [NUM_CH-1:0]    dac_rdy;

    codec_clkgen #(
        .MCLK_LOG2 (MCLK_LOG2),
        .SCLK_LOG2 (SCLK_LOG2),
        .SLOT_LOG2 (SLOT_LOG2)
    ) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .mclk_o    (mclk),
        .sclk_o    (sclk),
        .lrck_o    (lrck),
        .smp_en_o  (smp_en),
        .drv_en_o  (drv_en),
        .bit_idx_o (bit_idx),
        .chan_o    (chan)
    );

    codec_adc_rx #(
        .SAMPLE_W  (SAMPLE_W),
        .SLOT_LOG2 (SLOT_LOG2)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .smp_en_i  (smp_en),
        .bit_idx_i (bit_idx),
        .chan_i    (chan),
        .sdata_i   (adc_sdata),
        .rd_i      (rd_stb),
        .sel_i     (ch_sel),
        .word_l_o  (adc_left),
        .word_r_o  (adc_right),
        .rdy_o     (adc_rdy)
    );

    codec_dac_tx #(
        .SAMPLE_W  (SAMPLE_W),
        .SLOT_LOG2 (SLOT_LOG2)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .drv_en_i  (drv_en),
        .sclk_i    (sclk),
        .bit_idx_i (bit_idx),
        .chan_i    (chan),
        .wr_i      (wr_stb),
        .sel_i     (ch_sel),
        .word_l_i  (dac_left),
        .word_r_i  (dac_right),
        .rdy_o     (dac_rdy),
        .sdata_o   (dac_sdata)
    );

    assign adc_left_rdy  = adc_rdy[0];
    assign adc_right_rdy = adc_rdy[1];
    assign dac_left_rdy  = dac_rdy[0];
    assign dac_right_rdy = dac_rdy[1];

endmodule

// File: tb/test_codec_serial_port.sv
`timescale 1ns/1ps
module test_codec_serial_port;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk, lrck, sclk, dac_sdata;
    logic adc_sdata = 1'b0;
    logic ch_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] adc_left, adc_right;
    logic [7:0] dac_left = 8'h00, dac_right = 8'h00;
    logic adc_left_rdy, adc_right_rdy, dac_left_rdy, dac_right_rdy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    codec_serial_port i_codec_serial_port (
        .clk(clk), .rst(rst), .mclk(mclk), .lrck(lrck), .sclk(sclk),
        .adc_sdata(adc_sdata), .dac_sdata(dac_sdata), .ch_sel(ch_sel),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .adc_left(adc_left), .adc_right(adc_right),
        .adc_left_rdy(adc_left_rdy), .adc_right_rdy(adc_right_rdy),
        .dac_left(dac_left), .dac_right(dac_right),
        .dac_left_rdy(dac_left_rdy), .dac_right_rdy(dac_right_rdy)
    );

    // {adc left, adc right, dac left, dac right}
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        32'hA5_3C_81_7E, 32'h00_FF_01_80, 32'h80_01_FF_00,
        32'h5A_C3_66_99, 32'hFF_00_3C_A5, 32'h12_34_56_78
    };

    // converter model
    logic [7:0] adc_src_l = 8'h00, adc_src_r = 8'h00;
    logic [7:0] cur_adc = 8'h00, rx_sh = 8'h00;
    logic [7:0] rx_word [2] = '{8'h00, 8'h00};
    logic lr_q = 1'b0, sclk_q = 1'b0, ch_m = 1'b0;
    int bpos = 0;
    int pad_err = 0;

    always @(negedge clk) begin
        if (rst) begin
            lr_q = 1'b0; sclk_q = 1'b0; bpos = 0; ch_m = 1'b0;
            cur_adc = adc_src_l; adc_sdata = 1'b0;
        end else begin
            if (lrck != lr_q) begin
                bpos = 0; ch_m = lrck;
                cur_adc = lrck ? adc_src_r : adc_src_l;
            end else if (sclk_q && !sclk) begin
                bpos++;
            end
            if (!sclk_q && sclk) begin
                if (bpos >= 1 && bpos <= 8) begin
                    rx_sh = {rx_sh[6:0], dac_sdata};
                    if (bpos == 8) rx_word[ch_m] = rx_sh;
                end else if (dac_sdata !== 1'b0) begin
                    pad_err++;
                end
            end
            adc_sdata = (bpos >= 1 && bpos <= 8) ? cur_adc[8 - bpos] : 1'b0;
            lr_q = lrck; sclk_q = sclk;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic strobe(input bit is_wr, input logic sel);
        ch_sel = sel;
        if (is_wr) wr_stb = 1'b1; else rd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic wait_left_slot();
        @(negedge lrck);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] prev_dl, prev_dr;
        realtime t0;
        prev_dl = 8'h00; prev_dr = 8'h00;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk({mclk, lrck, sclk, dac_sdata} == 4'b0, "R1 clocks in reset", {mclk, lrck, sclk, dac_sdata}, 0);
        chk({adc_left_rdy, adc_right_rdy, dac_left_rdy, dac_right_rdy} == 4'b0, "R1 flags in reset",
            {adc_left_rdy, adc_right_rdy, dac_left_rdy, dac_right_rdy}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({lrck, sclk, dac_sdata, adc_left_rdy, adc_right_rdy, dac_left_rdy, dac_right_rdy} == 7'b0,
            "R1 first cycle", {lrck, sclk, dac_sdata}, 0);

        // flush the stale first-frame captures
        @(posedge lrck);
        @(negedge clk);
        while (!adc_right_rdy) @(negedge clk);
        strobe(1'b0, 1'b0);
        strobe(1'b0, 1'b1);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            adc_src_l = VEC[i][31:24];
            adc_src_r = VEC[i][23:16];
            wait_left_slot();
            while (!adc_left_rdy) @(negedge clk);
            chk(adc_left == VEC[i][31:24], "R4 left adc word", adc_left, VEC[i][31:24]);
            chk(dac_left_rdy == 1'b1, "R7 left dac flag at slot", dac_left_rdy, 1);
            chk(rx_word[0] == prev_dl, "R8 left serial word", rx_word[0], prev_dl);
            strobe(1'b0, 1'b0);
            chk(adc_left_rdy == 1'b0, "R5 left read clears", adc_left_rdy, 0);
            dac_left = VEC[i][15:8];
            strobe(1'b1, 1'b0);
            chk(dac_left_rdy == 1'b0, "R6 left write clears", dac_left_rdy, 0);
            prev_dl = VEC[i][15:8];

            while (!adc_right_rdy) @(negedge clk);
            chk(adc_right == VEC[i][23:16], "R3 R4 right adc word", adc_right, VEC[i][23:16]);
            chk(dac_right_rdy == 1'b1, "R7 right dac flag at slot", dac_right_rdy, 1);
            chk(rx_word[1] == prev_dr, "R8 right serial word", rx_word[1], prev_dr);
            strobe(1'b0, 1'b1);
            chk(adc_right_rdy == 1'b0, "R5 right read clears", adc_right_rdy, 0);
            dac_right = VEC[i][7:0];
            strobe(1'b1, 1'b1);
            chk(dac_right_rdy == 1'b0, "R6 right write clears", dac_right_rdy, 0);
            prev_dr = VEC[i][7:0];
        end

        // R9: no writes for a frame, the same word goes out again
        wait_left_slot();
        while (!adc_left_rdy) @(negedge clk);
        chk(rx_word[0] == prev_dl, "R8 last left word", rx_word[0], prev_dl);
        strobe(1'b0, 1'b0);
        while (!adc_right_rdy) @(negedge clk);
        wait_left_slot();
        while (!adc_left_rdy) @(negedge clk);
        chk(rx_word[0] == prev_dl, "R9 left word repeated", rx_word[0], prev_dl);

        // R5: read right, left flag untouched
        chk(adc_right_rdy == 1'b1, "R5 right flag pending", adc_right_rdy, 1);
        strobe(1'b0, 1'b1);
        chk(adc_right_rdy == 1'b0, "R5 selected flag cleared", adc_right_rdy, 0);
        chk(adc_left_rdy == 1'b1, "R5 other flag kept", adc_left_rdy, 1);

        // R6: write right, left dac flag untouched
        chk(dac_right_rdy == 1'b1, "R6 right dac flag pending", dac_right_rdy, 1);
        dac_right = 8'hC6;
        strobe(1'b1, 1'b1);
        chk(dac_right_rdy == 1'b0, "R6 selected dac flag cleared", dac_right_rdy, 0);
        chk(dac_left_rdy == 1'b1, "R6 other dac flag kept", dac_left_rdy, 1);
        @(negedge lrck);
        @(negedge clk);
        chk(rx_word[1] == 8'hC6, "R6 right word loaded", rx_word[1], 8'hC6);

        // R2, R3: clock periods
        @(posedge mclk); t0 = $realtime;
        @(posedge mclk);
        chk(($realtime - t0) == 10.0, "R2 mclk period", int'($realtime - t0), 10);
        @(posedge sclk); t0 = $realtime;
        @(posedge sclk);
        chk(($realtime - t0) == 40.0, "R2 sclk period", int'($realtime - t0), 40);
        @(posedge lrck); t0 = $realtime;
        @(negedge lrck);
        chk(($realtime - t0) == 1280.0, "R3 lrck half period", int'($realtime - t0), 1280);

        chk(pad_err == 0, "R8 zeros outside data bits", pad_err, 0);

        // R1: reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk({adc_left_rdy, adc_right_rdy, dac_left_rdy, dac_right_rdy, sclk, lrck} == 6'b0,
            "R1 re-reset", {adc_left_rdy, adc_right_rdy, dac_left_rdy, dac_right_rdy}, 0);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule